// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block collects fifteen interrupt lines, numbered 1 to 15, and presents one 4-bit request level to processor 0. Every line belongs to one of two priority classes, and a class register selects which. A request from the upper class always hides the lower class. Within the chosen class, the highest-numbered line wins. Bit 0 of every interrupt vector is reserved and never stored.

Software reaches the registers through a 32-bit word port with an 8-bit byte offset. The shared registers are the class selector, the pending set, a pending-clear strobe, a zero-reading status word and a broadcast selector. Each of up to sixteen processor slots has its own enable mask, force register and 4-bit extended word. Only slot 0 takes part in level selection. The other slots are storage only, although broadcast lines still reach their force registers.

Interrupt lines are sampled on every clock, and the block acts on each 0-to-1 and 1-to-0 change of a line. A line whose broadcast bit is set goes to the force register of every slot. Any other line goes to the pending register. The processor acknowledges an interrupt by presenting its number on the acknowledge port. The output level is registered and reflects every change one clock later.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset every register reads zero and `irq_level_o` is 0.
- R2: The request vector is (pending OR slot-0 force) AND slot-0 mask. Requests whose bit is set in the class register (word 0x00) are selected first. Lower-class requests count only when no upper-class request exists.
- R3: Within the selected class, `irq_level_o` is the highest-numbered active bit among 15..1. It is 0 when no bit is active.
- R4: A write to a slot force register (0x80 + 4*slot) computes new = (old OR wdata[15:1]) AND NOT wdata[31:17]. Each slot is independent.
- R5: A write to 0x08 replaces the slot-0 force register with wdata[15:1]. A read of 0x08 returns the slot-0 force register.
- R6: A write to 0x0C clears each pending bit (pending at 0x04) written as 1. Reads of 0x0C and 0x10 return 0. Writes to 0x04 and 0x10 have no effect.
- R7: On a rising input line n whose broadcast bit (word 0x14) is clear, pending bit n is set. If the broadcast bit is set, bit n is set in the force register of every slot instead. A falling line clears the same bits.
- R8: A valid acknowledge of number n clears pending bit n and slot-0 force bit n. If line n rises in the same cycle, the rise wins.
- R9: An extended register (0xC0 + 4*slot) keeps only wdata[3:0] and has no effect on the output level.
- R10: Offsets 0x18 to 0x3C read 0, and so do offsets with address bits [1:0] not zero. Writes to these offsets change nothing.
- R11: `irq_level_o` changes on the first rising clock edge after a register write, an input change or an acknowledge.
- R12: The class, mask, force and broadcast registers are 16 bits wide and always read with bit 0 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | 16 | Interrupt lines; bit 0 is ignored |
| reg_addr_i | input | 8 | Byte offset into the register window |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from the offset |
| ack_valid_i | input | 1 | Acknowledge strobe |
| ack_num_i | input | 4 | Number of the interrupt acknowledged |
| irq_level_o | output | 4 | Registered request level for processor 0 |

## Verification
The assertions assume that each rise or fall of an interrupt line lasts at least one clock. They also assume that an acknowledge is a one-cycle strobe whose number is meaningful only while the strobe is high. The acknowledge property excludes cycles in which a force write or a rising line could legally set the bit again. The stimulus changes each line at most once per cycle, always on the falling clock edge. It drives writes and acknowledges as single-cycle pulses, and it combines a rise with an acknowledge of the same bit only on purpose, to exercise the same-cycle ordering.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int IRQ_W  = 16;
  localparam int LVL_W  = $clog2(IRQ_W);
  localparam int SLOT_W = 4;

  typedef logic [IRQ_W-1:0] irq_vec_t;

  typedef enum logic [1:0] {
    GRP_GLOBAL = 2'd0,
    GRP_MASK   = 2'd1,
    GRP_FORCE  = 2'd2,
    GRP_EXT    = 2'd3
  } grp_e;

  localparam logic [3:0] WI_CLASS  = 4'd0;
  localparam logic [3:0] WI_PEND   = 4'd1;
  localparam logic [3:0] WI_FALIAS = 4'd2;
  localparam logic [3:0] WI_CLEAR  = 4'd3;
  localparam logic [3:0] WI_STAT   = 4'd4;
  localparam logic [3:0] WI_BCAST  = 4'd5;

  localparam irq_vec_t NZ_MASK = ~irq_vec_t'(1);
endpackage

// File: rtl/irq_hi_sel.sv
module irq_hi_sel #(
  parameter int W  = 16,
  parameter int OW = $clog2(W)
) (
  input  logic [W-1:0]  req_i,
  output logic [OW-1:0] idx_o
);
  // bit 0 is reserved; highest set bit wins
  always_comb begin
    idx_o = '0;
    for (int i = 1; i < W; i++) begin
      if (req_i[i]) idx_o = OW'(i);
    end
  end
endmodule

// File: rtl/irq_slot_bank.sv
module irq_slot_bank
  import irq_prio_pkg::*;
#(
  parameter int N_SLOTS = 16,
  parameter int EXT_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  grp_e              grp_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [31:0]       wdata_i,
  input  logic              alias_we_i,
  input  irq_vec_t          ack_clr_i,
  input  irq_vec_t          bc_set_i,
  input  irq_vec_t          bc_clr_i,
  output irq_vec_t          mask_o  [N_SLOTS],
  output irq_vec_t          force_o [N_SLOTS],
  output logic [EXT_W-1:0]  ext_o   [N_SLOTS],
  output irq_vec_t          mask0_nxt_o,
  output irq_vec_t          force0_nxt_o
);
  irq_vec_t set_v, clr_v;
  assign set_v = wdata_i[IRQ_W-1:0] & NZ_MASK;
  assign clr_v = wdata_i[2*IRQ_W-1:IRQ_W] & NZ_MASK;

  for (genvar k = 0; k < N_SLOTS; k++) begin : g_slot
    logic hit;
    irq_vec_t m_d, f_d;
    logic [EXT_W-1:0] e_d;

    assign hit = we_i && (slot_i == SLOT_W'(k));

    always_comb begin
      m_d = mask_o[k];
      if (hit && grp_i == GRP_MASK) m_d = set_v;
      e_d = ext_o[k];
      if (hit && grp_i == GRP_EXT) e_d = wdata_i[EXT_W-1:0];
      f_d = force_o[k];
      if (hit && grp_i == GRP_FORCE) f_d = (f_d | set_v) & ~clr_v;
      if (k == 0) begin
        if (alias_we_i) f_d = set_v;
        f_d = f_d & ~ack_clr_i;
      end
      // line events are applied last so a rise beats an acknowledge
      f_d = (f_d | bc_set_i) & ~bc_clr_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mask_o[k]  <= '0;
        force_o[k] <= '0;
        ext_o[k]   <= '0;
      end else begin
        mask_o[k]  <= m_d;
        force_o[k] <= f_d;
        ext_o[k]   <= e_d;
      end
    end

    if (k == 0) begin : g_nxt
      assign mask0_nxt_o  = m_d;
      assign force0_nxt_o = f_d;
    end
  end

  a_r12_force_bit0 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !force_o[0][0] && !mask_o[0][0]);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int N_SLOTS = 16,
  parameter int EXT_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IRQ_W-1:0]  irq_i,
  input  logic [7:0]        reg_addr_i,
  input  logic              reg_we_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              ack_valid_i,
  input  logic [LVL_W-1:0]  ack_num_i,
  output logic [LVL_W-1:0]  irq_level_o
);
  logic [5:0] widx;
  logic       aligned, glob_we, alias_we;
  grp_e       grp;

  assign widx     = reg_addr_i[7:2];
  assign aligned  = (reg_addr_i[1:0] == 2'b00);
  assign grp      = grp_e'(widx[5:4]);
  assign glob_we  = reg_we_i && aligned && grp == GRP_GLOBAL;
  assign alias_we = glob_we && widx[3:0] == WI_FALIAS;

  irq_vec_t cls_q, pend_q, bc_q, irq_q;
  irq_vec_t cls_d, pend_d, bc_d, clr_wr;
  irq_vec_t rise, fall, ack_clr;
  irq_vec_t mask_s [N_SLOTS];
  irq_vec_t force_s[N_SLOTS];
  logic [EXT_W-1:0] ext_s[N_SLOTS];
  irq_vec_t mask0_d, force0_d, req_d, sel_d;
  logic [LVL_W-1:0] lvl_d, lvl_q;

  assign rise    = irq_i & ~irq_q & NZ_MASK;
  assign fall    = ~irq_i & irq_q & NZ_MASK;
  assign ack_clr = ack_valid_i ? ((irq_vec_t'(1) << ack_num_i) & NZ_MASK) : '0;

  always_comb begin
    cls_d  = cls_q;
    bc_d   = bc_q;
    clr_wr = '0;
    if (glob_we) begin
      case (widx[3:0])
        WI_CLASS: cls_d  = reg_wdata_i[IRQ_W-1:0] & NZ_MASK;
        WI_CLEAR: clr_wr = reg_wdata_i[IRQ_W-1:0] & NZ_MASK;
        WI_BCAST: bc_d   = reg_wdata_i[IRQ_W-1:0] & NZ_MASK;
        default: ;
      endcase
    end
    pend_d = ((pend_q & ~clr_wr & ~ack_clr) | (rise & ~bc_q)) & ~(fall & ~bc_q);
  end

  irq_slot_bank #(.N_SLOTS(N_SLOTS), .EXT_W(EXT_W)) u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i && aligned),
    .grp_i       (grp),
    .slot_i      (widx[3:0]),
    .wdata_i     (reg_wdata_i),
    .alias_we_i  (alias_we),
    .ack_clr_i   (ack_clr),
    .bc_set_i    (rise & bc_q),
    .bc_clr_i    (fall & bc_q),
    .mask_o      (mask_s),
    .force_o     (force_s),
    .ext_o       (ext_s),
    .mask0_nxt_o (mask0_d),
    .force0_nxt_o(force0_d)
  );

  // level is evaluated on next-state values so it lands one clock after the cause
  assign req_d = (pend_d | force0_d) & mask0_d;
  assign sel_d = (|(req_d & cls_d)) ? (req_d & cls_d) : (req_d & ~cls_d);

  irq_hi_sel #(.W(IRQ_W), .OW(LVL_W)) u_sel (.req_i(sel_d), .idx_o(lvl_d));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cls_q  <= '0;
      pend_q <= '0;
      bc_q   <= '0;
      irq_q  <= '0;
      lvl_q  <= '0;
    end else begin
      cls_q  <= cls_d;
      pend_q <= pend_d;
      bc_q   <= bc_d;
      irq_q  <= irq_i & NZ_MASK;
      lvl_q  <= lvl_d;
    end
  end

  assign irq_level_o = lvl_q;

  always_comb begin
    reg_rdata_o = '0;
    if (aligned) begin
      case (grp)
        GRP_GLOBAL: begin
          case (widx[3:0])
            WI_CLASS:  reg_rdata_o = {16'h0, cls_q};
            WI_PEND:   reg_rdata_o = {16'h0, pend_q};
            WI_FALIAS: reg_rdata_o = {16'h0, force_s[0]};
            WI_BCAST:  reg_rdata_o = {16'h0, bc_q};
            default:   reg_rdata_o = '0;
          endcase
        end
        GRP_MASK:  if (int'(widx[3:0]) < N_SLOTS) reg_rdata_o = {16'h0, mask_s[widx[3:0]]};
        GRP_FORCE: if (int'(widx[3:0]) < N_SLOTS) reg_rdata_o = {16'h0, force_s[widx[3:0]]};
        GRP_EXT:   if (int'(widx[3:0]) < N_SLOTS) reg_rdata_o = 32'(ext_s[widx[3:0]]);
        default: ;
      endcase
    end
  end

  // properties over registered state
  irq_vec_t req_q, cls_act_q;
  assign req_q     = (pend_q | force_s[0]) & mask_s[0];
  assign cls_act_q = (|(req_q & cls_q)) ? cls_q : ~cls_q;

  a_r3_zero_iff_idle : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_level_o == '0) == ((req_q & NZ_MASK) == '0));

  a_r2_upper_first : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_level_o != '0) |-> (req_q[irq_level_o] && (cls_q[irq_level_o] || (req_q & cls_q) == '0)));

  a_r3_no_higher : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_level_o != '0) |-> (((req_q & cls_act_q) >> irq_level_o) >> 1) == '0);

  a_r6_clear_reads_zero : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == 8'h0C || reg_addr_i == 8'h10) |-> reg_rdata_o == '0);

  a_r8_ack_clears : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_valid_i && ack_num_i != '0 && !rise[ack_num_i] &&
     !(reg_we_i && aligned && (widx == 6'd2 || widx == 6'd32)))
    |=> (!pend_q[$past(ack_num_i)] && !force_s[0][$past(ack_num_i)]));

  a_r12_bit0_clear : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_q[0] && !cls_q[0] && !bc_q[0]);
endmodule

// File: tb/sim_irq_prio_ctrl.sv
module sim_irq_prio_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic [15:0] irq = '0;
  logic [7:0]  addr = '0;
  logic        we = 0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ack_v = 0;
  logic [3:0]  ack_n = '0;
  logic [3:0]  level;

  int checks = 0, errors = 0;
  bit done = 0;

  irq_prio_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .reg_addr_i(addr),
    .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .ack_valid_i(ack_v), .ack_num_i(ack_n), .irq_level_o(level)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  logic [15:0] m_cls, m_pend, m_bc, m_prev;
  logic [15:0] m_mask[16], m_force[16];
  logic [3:0]  m_ext[16];
  int m_level;

  function automatic int pick(logic [15:0] req, logic [15:0] cls);
    logic [15:0] s;
    s = ((req & cls) != 0) ? (req & cls) : (req & ~cls);
    for (int b = 15; b >= 1; b--) if (s[b]) return b;
    return 0;
  endfunction

  task automatic model_reset();
    m_cls = 0; m_pend = 0; m_bc = 0; m_prev = 0; m_level = 0;
    for (int s = 0; s < 16; s++) begin m_mask[s] = 0; m_force[s] = 0; m_ext[s] = 0; end
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (rst_n) begin
      logic [15:0] bc_old;
      int wi;
      bc_old = m_bc;
      wi = addr[7:2];
      if (we && addr[1:0] == 0) begin
        if (wi == 0) m_cls = wdata[15:0] & 16'hFFFE;
        else if (wi == 2) m_force[0] = wdata[15:0] & 16'hFFFE;
        else if (wi == 3) m_pend = m_pend & ~wdata[15:0];
        else if (wi == 5) m_bc = wdata[15:0] & 16'hFFFE;
        else if (wi >= 16 && wi < 32) m_mask[wi-16] = wdata[15:0] & 16'hFFFE;
        else if (wi >= 32 && wi < 48)
          m_force[wi-32] = (m_force[wi-32] | (wdata[15:0] & 16'hFFFE)) & ~(wdata[31:16] & 16'hFFFE);
        else if (wi >= 48) m_ext[wi-48] = wdata[3:0];
      end
      if (ack_v) begin
        m_pend[ack_n] = 1'b0;
        m_force[0][ack_n] = 1'b0;
      end
      for (int b = 1; b < 16; b++) begin
        if (irq[b] && !m_prev[b]) begin
          if (bc_old[b]) for (int s = 0; s < 16; s++) m_force[s][b] = 1'b1;
          else m_pend[b] = 1'b1;
        end else if (!irq[b] && m_prev[b]) begin
          if (bc_old[b]) for (int s = 0; s < 16; s++) m_force[s][b] = 1'b0;
          else m_pend[b] = 1'b0;
        end
      end
      m_prev = irq & 16'hFFFE;
      m_level = pick((m_pend | m_force[0]) & m_mask[0], m_cls);
    end
  end

  // per-cycle comparison of the output level (R11, R2, R3)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (int'(level) != m_level) begin
        errors++;
        $display("FAIL R11 cycle compare: level=%0d expected=%0d", level, m_level);
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0; addr = 8'h00; wdata = '0;
  endtask

  task automatic rd(string req, logic [7:0] a, logic [31:0] exp);
    @(negedge clk); addr = a; #1;
    chk(req, rdata, exp);
    addr = 8'h00;
  endtask

  task automatic set_line(int b, logic v);
    @(negedge clk); irq[b] = v;
    @(negedge clk); #1;
  endtask

  task automatic ack(logic [3:0] n);
    @(negedge clk); ack_v = 1; ack_n = n;
    @(negedge clk); ack_v = 0; ack_n = '0; #1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    #1 chk("R1 level", 32'(level), 0);
    rd("R1 class", 8'h00, 0);
    rd("R1 pending", 8'h04, 0);
    rd("R1 mask0", 8'h40, 0);
    rd("R1 force0", 8'h80, 0);

    // R12 mask drops bit 0
    wr(8'h40, 32'h0000_FFFF);
    rd("R12 mask0", 8'h40, 32'h0000_FFFE);

    // R7 rise sets pending
    set_line(5, 1);
    chk("R7 level after rise", 32'(level), 5);
    rd("R7 pending", 8'h04, 32'h0000_0020);

    // R3 highest wins
    set_line(9, 1);
    chk("R3 level", 32'(level), 9);

    // R2 upper class first; R12 class drops bit 0
    wr(8'h00, 32'h0000_0021);
    #1 chk("R2 level", 32'(level), 5);
    rd("R12 class", 8'h00, 32'h0000_0020);

    // R7 fall clears pending
    set_line(5, 0);
    chk("R7 level after fall", 32'(level), 9);
    rd("R7 pending after fall", 8'h04, 32'h0000_0200);

    // R6 clear register
    wr(8'h0C, 32'h0000_0200);
    #1 chk("R6 level", 32'(level), 0);
    rd("R6 pending cleared", 8'h04, 0);
    rd("R6 clear reads 0", 8'h0C, 0);
    rd("R6 status reads 0", 8'h10, 0);
    wr(8'h04, 32'h0000_FFFF);
    rd("R6 pending write ignored", 8'h04, 0);
    wr(8'h10, 32'hFFFF_FFFF);
    rd("R6 status write ignored", 8'h10, 0);
    #1 chk("R6 level stays", 32'(level), 0);

    // R5 alias
    wr(8'h08, 32'h0000_0009);
    #1 chk("R5 level", 32'(level), 3);
    rd("R5 alias read", 8'h08, 32'h0000_0008);
    rd("R5 slot0 force", 8'h80, 32'h0000_0008);

    // R4 set/clear halves
    wr(8'h80, 32'h0008_0004);
    #1 chk("R4 level", 32'(level), 2);
    rd("R4 force0", 8'h80, 32'h0000_0004);

    // R8 ack
    ack(4'd2);
    chk("R8 level after ack", 32'(level), 0);
    rd("R8 force0 cleared", 8'h80, 0);

    // R4 other slot independent
    wr(8'h8C, 32'h0000_0102);
    rd("R4 slot3 force", 8'h8C, 32'h0000_0102);
    #1 chk("R4 slot3 no effect", 32'(level), 0);

    // R7 broadcast
    wr(8'h14, 32'h0000_0041);
    rd("R12 broadcast", 8'h14, 32'h0000_0040);
    set_line(6, 1);
    chk("R7 broadcast level", 32'(level), 6);
    rd("R7 bc force0", 8'h80, 32'h0000_0040);
    rd("R7 bc force3", 8'h8C, 32'h0000_0142);
    rd("R7 bc pending untouched", 8'h04, 0);
    set_line(6, 0);
    chk("R7 broadcast fall level", 32'(level), 0);
    rd("R7 bc force3 after fall", 8'h8C, 32'h0000_0102);

    // R9 extended
    wr(8'hC0, 32'hFFFF_FFFF);
    rd("R9 ext0", 8'hC0, 32'h0000_000F);
    #1 chk("R9 no effect", 32'(level), 0);

    // R10 unmapped
    wr(8'h20, 32'hFFFF_FFFF);
    rd("R10 unmapped read", 8'h20, 0);
    rd("R10 class unchanged", 8'h00, 32'h0000_0020);
    rd("R10 mask unchanged", 8'h40, 32'h0000_FFFE);
    rd("R10 misaligned read", 8'h41, 0);
    wr(8'h41, 32'h0000_0000);
    rd("R10 misaligned write ignored", 8'h40, 32'h0000_FFFE);

    // R8 rise beats ack in same cycle
    @(negedge clk); irq[4] = 1; ack_v = 1; ack_n = 4'd4;
    @(negedge clk); ack_v = 0; ack_n = '0; #1;
    chk("R8 rise wins", 32'(level), 4);
    rd("R8 pending bit4", 8'h04, 32'h0000_0010);
    set_line(4, 0);

    // R11 one-clock latency
    @(negedge clk); irq[12] = 1; #1;
    chk("R11 before edge", 32'(level), 0);
    @(negedge clk); #1;
    chk("R11 after edge", 32'(level), 12);
    set_line(12, 0);
    chk("R11 drop", 32'(level), 0);

    repeat (2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule